// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block predicts, for a load or store being dispatched in an out-of-order core, which earlier in-flight store it should wait for. It has two tables. A set-ID table is indexed by instruction address. Each of its entries holds a store-set number and a valid flag. A last-store table has one entry per store set. Each of its entries holds the sequence number and thread of the youngest store of that set that has been dispatched and has not yet issued, plus a valid flag.

When a memory-ordering violation is reported, the offending store and load are put into a common store set. Stores that belong to a set record themselves in the last-store table at dispatch. A lookup on any instruction address returns the recorded sequence number, or zero when no dependence is predicted. Issue of the recorded store, a squash of the store's thread, or a global clear removes the record.

Top module: `mdp_store_set`

## Requirements
- R1: The set-ID table entry for an address is selected by address bits [OFF_BITS+log2(SID_ENTRIES)-1 : OFF_BITS]. With the defaults this is pc[7:2], so two addresses that differ only outside these bits share one entry.
- R2: A fresh set number is taken from the store address pc as (pc XOR (pc >> 10)) mod SET_ENTRIES. Two violations whose store addresses give the same value therefore land in the same set.
- R3: When a violation is reported, the set-ID entries of the store and the load are merged as follows. If both entries are invalid, both receive the fresh number. If exactly one is valid, the other copies its number. If both are valid, both take the smaller of the two numbers. In every case both entries are valid afterwards.
- R4: A store insert whose set-ID entry is valid writes its sequence number and thread into the last-store entry of that set and marks that entry valid. A store insert whose set-ID entry is invalid changes nothing.
- R5: The lookup output is combinational. It equals the last-store sequence number when both the set-ID entry and the last-store entry are valid, and 0 otherwise. Table writes become visible only after the next rising clock edge.
- R6: A load insert (ins_is_store_i = 0) changes no state.
- R7: A store issue clears the last-store entry of its set only when that entry holds the issued sequence number. A load issue (iss_is_store_i = 0) changes nothing.
- R8: A squash clears every last-store entry whose thread equals sq_tid_i and whose sequence number is strictly greater than sq_seq_i, compared as unsigned numbers. Entries of other threads, and entries at or below that point, are kept.
- R9: A clear drops every valid flag in both tables at the next edge and overrides all other requests in that cycle. Reset has the same effect.
- R10: Within one cycle, a store insert to a set overrides an issue or squash that would clear that set. A store insert reads the set-ID table as it was before any violation update made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Invalidate both tables |
| viol_valid_i | input | 1 | Violation report strobe |
| viol_store_pc_i | input | PC_W | Address of the older store in the violation |
| viol_load_pc_i | input | PC_W | Address of the younger load in the violation |
| ins_valid_i | input | 1 | Dispatch insert strobe |
| ins_is_store_i | input | 1 | Inserted instruction is a store |
| ins_pc_i | input | PC_W | Inserted instruction address |
| ins_seq_i | input | SEQ_W | Inserted instruction sequence number |
| ins_tid_i | input | TID_W | Inserted instruction thread |
| look_pc_i | input | PC_W | Address to look up |
| look_dep_seq_o | output | SEQ_W | Sequence number to wait for, 0 if none |
| iss_valid_i | input | 1 | Issue notification strobe |
| iss_is_store_i | input | 1 | Issued instruction is a store |
| iss_pc_i | input | PC_W | Issued instruction address |
| iss_seq_i | input | SEQ_W | Issued instruction sequence number |
| sq_valid_i | input | 1 | Squash strobe |
| sq_tid_i | input | TID_W | Thread being squashed |
| sq_seq_i | input | SEQ_W | Youngest surviving sequence number |

## Verification
The bench targets set merging when both instructions already belong to different sets. A design that kept the larger number, or left one side unchanged, would leave one instruction's lookup pointing at a stale store. Issue of an older store in a set that has since recorded a younger one is also exercised: a design that skipped the sequence-number match would wrongly drop the dependence. Squash is tested at its exact boundary (equal sequence number, and a different thread), where an off-by-one or a missing thread match clears a live record. Same-cycle collisions are checked too: insert against issue, insert against squash, insert against a violation on the same address, and clear against insert. Each of these shows up as a wrong lookup value one cycle later.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

  // Kind of set-ID merge performed for a violation, from the two valid flags.
  typedef enum logic [1:0] {
    MRG_FRESH   = 2'd0,  // neither belongs to a set
    MRG_FROM_ST = 2'd1,  // only store has a set
    MRG_FROM_LD = 2'd2,  // only load has a set
    MRG_MIN     = 2'd3   // both have sets
  } merge_e;

  function automatic merge_e merge_kind(input logic st_vld, input logic ld_vld);
    return merge_e'({ld_vld, st_vld});
  endfunction

  // Address fold used to make a fresh set number (caller keeps the low bits).
  function automatic logic [63:0] fold_pc(input logic [63:0] pc);
    return pc ^ (pc >> 10);
  endfunction

  // Unsigned "younger than" test for squash.
  function automatic logic seq_after(input logic [63:0] a, input logic [63:0] b);
    return a > b;
  endfunction

endpackage

// File: rtl/mdp_setid_table.sv
module mdp_setid_table #(
  parameter int PC_W        = 32,
  parameter int SID_ENTRIES = 64,
  parameter int SET_ENTRIES = 16,
  parameter int OFF_BITS    = 2,
  parameter int N_RD        = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic [PC_W-1:0]            rd_pc_i  [N_RD],
  output logic                       rd_vld_o [N_RD],
  output logic [$clog2(SET_ENTRIES)-1:0] rd_id_o [N_RD],
  input  logic                       viol_en_i,
  input  logic [PC_W-1:0]            viol_st_pc_i,
  input  logic [PC_W-1:0]            viol_ld_pc_i,
  output logic [$clog2(SID_ENTRIES)-1:0] viol_st_idx_o,
  output logic [$clog2(SID_ENTRIES)-1:0] viol_ld_idx_o,
  output logic [SID_ENTRIES-1:0]     vld_vec_o
);
  import mdp_pkg::*;

  localparam int IW = $clog2(SID_ENTRIES);
  localparam int SW = $clog2(SET_ENTRIES);

  function automatic logic [IW-1:0] pc_index(input logic [PC_W-1:0] pc);
    logic [PC_W-1:0] sh;
    sh = pc >> OFF_BITS;
    return sh[IW-1:0];
  endfunction

  logic [SID_ENTRIES-1:0] vld_q;
  logic [SW-1:0]          id_q [SID_ENTRIES];

  assign vld_vec_o = vld_q;

  for (genvar g = 0; g < N_RD; g++) begin : gen_rd
    logic [IW-1:0] idx;
    assign idx         = pc_index(rd_pc_i[g]);
    assign rd_vld_o[g] = vld_q[idx];
    assign rd_id_o[g]  = id_q[idx];
  end

  logic [IW-1:0] st_idx, ld_idx;
  logic          st_vld, ld_vld;
  logic [SW-1:0] st_id, ld_id, fresh_id, min_id;
  logic [63:0]   folded;
  merge_e        kind;

  assign st_idx   = pc_index(viol_st_pc_i);
  assign ld_idx   = pc_index(viol_ld_pc_i);
  assign st_vld   = vld_q[st_idx];
  assign ld_vld   = vld_q[ld_idx];
  assign st_id    = id_q[st_idx];
  assign ld_id    = id_q[ld_idx];
  assign folded   = fold_pc(64'(viol_st_pc_i));
  assign fresh_id = folded[SW-1:0];
  assign min_id   = (st_id < ld_id) ? st_id : ld_id;
  assign kind     = merge_kind(st_vld, ld_vld);

  assign viol_st_idx_o = st_idx;
  assign viol_ld_idx_o = ld_idx;

  logic unused_fold;
  assign unused_fold = ^folded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < SID_ENTRIES; i++) id_q[i] <= '0;
    end else if (clear_i) begin
      vld_q <= '0;
    end else if (viol_en_i) begin
      vld_q[st_idx] <= 1'b1;
      vld_q[ld_idx] <= 1'b1;
      unique case (kind)
        MRG_FRESH: begin
          id_q[st_idx] <= fresh_id;
          id_q[ld_idx] <= fresh_id;
        end
        MRG_FROM_ST: id_q[ld_idx] <= st_id;
        MRG_FROM_LD: id_q[st_idx] <= ld_id;
        default: begin
          id_q[st_idx] <= min_id;
          id_q[ld_idx] <= min_id;
        end
      endcase
    end
  end

endmodule

// File: rtl/mdp_last_store_table.sv
module mdp_last_store_table #(
  parameter int SET_ENTRIES = 16,
  parameter int SEQ_W       = 16,
  parameter int TID_W       = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear_i,
  input  logic                           wr_en_i,
  input  logic [$clog2(SET_ENTRIES)-1:0] wr_set_i,
  input  logic [SEQ_W-1:0]               wr_seq_i,
  input  logic [TID_W-1:0]               wr_tid_i,
  input  logic                           iss_en_i,
  input  logic [$clog2(SET_ENTRIES)-1:0] iss_set_i,
  input  logic [SEQ_W-1:0]               iss_seq_i,
  input  logic                           sq_en_i,
  input  logic [TID_W-1:0]               sq_tid_i,
  input  logic [SEQ_W-1:0]               sq_seq_i,
  input  logic [$clog2(SET_ENTRIES)-1:0] rd_set_i,
  output logic                           rd_vld_o,
  output logic [SEQ_W-1:0]               rd_seq_o,
  output logic [SET_ENTRIES-1:0]         vld_vec_o,
  output logic [SET_ENTRIES-1:0]         iss_hit_vec_o,
  output logic [SET_ENTRIES-1:0]         sq_hit_vec_o
);
  import mdp_pkg::*;

  localparam int SW = $clog2(SET_ENTRIES);

  logic [SEQ_W-1:0] seq_arr [SET_ENTRIES];

  for (genvar e = 0; e < SET_ENTRIES; e++) begin : gen_ent
    logic             v_q;
    logic [SEQ_W-1:0] seq_q;
    logic [TID_W-1:0] tid_q;
    logic             wr_hit, iss_hit, sq_hit;

    assign wr_hit  = wr_en_i && (wr_set_i == SW'(e));
    assign iss_hit = iss_en_i && (iss_set_i == SW'(e)) && (seq_q == iss_seq_i);
    assign sq_hit  = sq_en_i && (tid_q == sq_tid_i) &&
                     seq_after(64'(seq_q), 64'(sq_seq_i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        seq_q <= '0;
        tid_q <= '0;
      end else if (clear_i) begin
        v_q <= 1'b0;
      end else if (wr_hit) begin
        v_q   <= 1'b1;
        seq_q <= wr_seq_i;
        tid_q <= wr_tid_i;
      end else if (iss_hit || sq_hit) begin
        v_q <= 1'b0;
      end
    end

    assign vld_vec_o[e]     = v_q;
    assign seq_arr[e]       = seq_q;
    assign iss_hit_vec_o[e] = iss_hit;
    assign sq_hit_vec_o[e]  = sq_hit;
  end

  assign rd_vld_o = vld_vec_o[rd_set_i];
  assign rd_seq_o = seq_arr[rd_set_i];

endmodule

// File: rtl/mdp_store_set.sv
module mdp_store_set #(
  parameter int PC_W        = 32,
  parameter int SEQ_W       = 16,
  parameter int TID_W       = 2,
  parameter int SID_ENTRIES = 64,
  parameter int SET_ENTRIES = 16,
  parameter int OFF_BITS    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             viol_valid_i,
  input  logic [PC_W-1:0]  viol_store_pc_i,
  input  logic [PC_W-1:0]  viol_load_pc_i,
  input  logic             ins_valid_i,
  input  logic             ins_is_store_i,
  input  logic [PC_W-1:0]  ins_pc_i,
  input  logic [SEQ_W-1:0] ins_seq_i,
  input  logic [TID_W-1:0] ins_tid_i,
  input  logic [PC_W-1:0]  look_pc_i,
  output logic [SEQ_W-1:0] look_dep_seq_o,
  input  logic             iss_valid_i,
  input  logic             iss_is_store_i,
  input  logic [PC_W-1:0]  iss_pc_i,
  input  logic [SEQ_W-1:0] iss_seq_i,
  input  logic             sq_valid_i,
  input  logic [TID_W-1:0] sq_tid_i,
  input  logic [SEQ_W-1:0] sq_seq_i
);
  localparam int IW   = $clog2(SID_ENTRIES);
  localparam int SW   = $clog2(SET_ENTRIES);
  localparam int RD_LOOK = 0;
  localparam int RD_INS  = 1;
  localparam int RD_ISS  = 2;
  localparam int N_RD    = 3;

  // Read ports of the set-ID table
  logic [PC_W-1:0] rd_pc  [N_RD];
  logic            rd_vld [N_RD];
  logic [SW-1:0]   rd_id  [N_RD];

  assign rd_pc[RD_LOOK] = look_pc_i;
  assign rd_pc[RD_INS]  = ins_pc_i;
  assign rd_pc[RD_ISS]  = iss_pc_i;

  // Named internal events for the checker
  logic                   look_sid_vld;
  logic                   ins_wr_ev;
  logic [SW-1:0]          ins_set;
  logic                   iss_ev;
  logic [IW-1:0]          viol_st_idx, viol_ld_idx;
  logic [SID_ENTRIES-1:0] sid_vld_vec;
  logic [SET_ENTRIES-1:0] lfst_vld_vec, iss_hit_vec, sq_hit_vec;
  logic                   lfst_rd_vld;
  logic [SEQ_W-1:0]       lfst_rd_seq;

  assign look_sid_vld = rd_vld[RD_LOOK];
  assign ins_wr_ev    = ins_valid_i && ins_is_store_i && rd_vld[RD_INS];
  assign ins_set      = rd_id[RD_INS];
  assign iss_ev       = iss_valid_i && iss_is_store_i && rd_vld[RD_ISS];

  mdp_setid_table #(
    .PC_W(PC_W), .SID_ENTRIES(SID_ENTRIES), .SET_ENTRIES(SET_ENTRIES),
    .OFF_BITS(OFF_BITS), .N_RD(N_RD)
  ) u_sid (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .rd_pc_i(rd_pc), .rd_vld_o(rd_vld), .rd_id_o(rd_id),
    .viol_en_i(viol_valid_i),
    .viol_st_pc_i(viol_store_pc_i), .viol_ld_pc_i(viol_load_pc_i),
    .viol_st_idx_o(viol_st_idx), .viol_ld_idx_o(viol_ld_idx),
    .vld_vec_o(sid_vld_vec)
  );

  mdp_last_store_table #(
    .SET_ENTRIES(SET_ENTRIES), .SEQ_W(SEQ_W), .TID_W(TID_W)
  ) u_lst (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .wr_en_i(ins_wr_ev), .wr_set_i(ins_set),
    .wr_seq_i(ins_seq_i), .wr_tid_i(ins_tid_i),
    .iss_en_i(iss_ev), .iss_set_i(rd_id[RD_ISS]), .iss_seq_i(iss_seq_i),
    .sq_en_i(sq_valid_i), .sq_tid_i(sq_tid_i), .sq_seq_i(sq_seq_i),
    .rd_set_i(rd_id[RD_LOOK]),
    .rd_vld_o(lfst_rd_vld), .rd_seq_o(lfst_rd_seq),
    .vld_vec_o(lfst_vld_vec),
    .iss_hit_vec_o(iss_hit_vec), .sq_hit_vec_o(sq_hit_vec)
  );

  assign look_dep_seq_o = (look_sid_vld && lfst_rd_vld) ? lfst_rd_seq : '0;

  logic unused_hits;
  assign unused_hits = ^{iss_hit_vec, sq_hit_vec};

endmodule

// File: rtl/mdp_store_set_chk.sv
module mdp_store_set_chk #(
  parameter int SEQ_W       = 16,
  parameter int SID_ENTRIES = 64,
  parameter int SET_ENTRIES = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           clear_i,
  input logic                           viol_valid_i,
  input logic                           ins_valid_i,
  input logic                           ins_is_store_i,
  input logic                           iss_valid_i,
  input logic                           sq_valid_i,
  input logic [SEQ_W-1:0]               look_dep_seq_o,
  input logic                           look_sid_vld,
  input logic                           ins_wr_ev,
  input logic [$clog2(SET_ENTRIES)-1:0] ins_set,
  input logic [$clog2(SID_ENTRIES)-1:0] viol_st_idx,
  input logic [$clog2(SID_ENTRIES)-1:0] viol_ld_idx,
  input logic [SID_ENTRIES-1:0]         sid_vld_vec,
  input logic [SET_ENTRIES-1:0]         lfst_vld_vec
);

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (sid_vld_vec == '0 && lfst_vld_vec == '0)); // R9

  AST_LOAD_INSERT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_i && !ins_is_store_i && !viol_valid_i && !iss_valid_i &&
     !sq_valid_i && !clear_i) |=> ($stable(sid_vld_vec) && $stable(lfst_vld_vec))); // R6

  AST_VIOL_JOINS: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid_i && !clear_i) |=>
      (sid_vld_vec[$past(viol_st_idx)] && sid_vld_vec[$past(viol_ld_idx)])); // R3

  AST_ISSUE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid_i && !ins_valid_i && !sq_valid_i && !clear_i) |=>
      ($countones($past(lfst_vld_vec) & ~lfst_vld_vec) <= 1)); // R7

  AST_SQUASH_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid_i && !ins_valid_i && !clear_i) |=>
      ((lfst_vld_vec & ~$past(lfst_vld_vec)) == '0)); // R8

  AST_INSERT_VALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_wr_ev && !clear_i) |=> lfst_vld_vec[$past(ins_set)]); // R4

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !look_sid_vld |-> (look_dep_seq_o == '0)); // R5

endmodule

bind mdp_store_set mdp_store_set_chk #(
  .SEQ_W(SEQ_W), .SID_ENTRIES(SID_ENTRIES), .SET_ENTRIES(SET_ENTRIES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
  .viol_valid_i(viol_valid_i), .ins_valid_i(ins_valid_i),
  .ins_is_store_i(ins_is_store_i), .iss_valid_i(iss_valid_i),
  .sq_valid_i(sq_valid_i), .look_dep_seq_o(look_dep_seq_o),
  .look_sid_vld(look_sid_vld), .ins_wr_ev(ins_wr_ev), .ins_set(ins_set),
  .viol_st_idx(viol_st_idx), .viol_ld_idx(viol_ld_idx),
  .sid_vld_vec(sid_vld_vec), .lfst_vld_vec(lfst_vld_vec)
);

// File: tb/mdp_store_set_tb.sv
module mdp_store_set_tb;
  localparam int PC_W = 32, SEQ_W = 16, TID_W = 2;
  localparam int NSID = 64, NSET = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clear_i = 0, viol_valid_i = 0, ins_valid_i = 0, ins_is_store_i = 0;
  logic iss_valid_i = 0, iss_is_store_i = 0, sq_valid_i = 0;
  logic [PC_W-1:0] viol_store_pc_i = 0, viol_load_pc_i = 0, ins_pc_i = 0;
  logic [PC_W-1:0] look_pc_i = 0, iss_pc_i = 0;
  logic [SEQ_W-1:0] ins_seq_i = 0, iss_seq_i = 0, sq_seq_i = 0, look_dep_seq_o;
  logic [TID_W-1:0] ins_tid_i = 0, sq_tid_i = 0;

  int n_chk = 0, n_err = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  mdp_store_set u_dut (.*);

  // ---------------- behavioural reference ----------------
  int sid_tab[NSID]; bit sid_ok[NSID];
  int lst_seq[NSET]; int lst_tid[NSET]; bit lst_ok[NSET];

  function automatic int ix(input int unsigned pc); return (pc / 4) % NSID; endfunction
  function automatic int hsh(input int unsigned pc); return (pc ^ (pc >> 10)) % NSET; endfunction
  function automatic int ref_look(input int unsigned pc);
    int s;
    if (!sid_ok[ix(pc)]) return 0;
    s = sid_tab[ix(pc)];
    return lst_ok[s] ? lst_seq[s] : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || clear_i) begin
      for (int i = 0; i < NSID; i++) sid_ok[i] = 0;
      for (int i = 0; i < NSET; i++) lst_ok[i] = 0;
    end else begin
      int wset, iset, a, b, m;
      bit wdo, ido;
      wdo = ins_valid_i && ins_is_store_i && sid_ok[ix(ins_pc_i)];
      wset = sid_tab[ix(ins_pc_i)];
      ido = iss_valid_i && iss_is_store_i && sid_ok[ix(iss_pc_i)];
      iset = sid_tab[ix(iss_pc_i)];
      if (viol_valid_i) begin
        a = ix(viol_store_pc_i); b = ix(viol_load_pc_i);
        if (!sid_ok[a] && !sid_ok[b]) begin
          sid_tab[a] = hsh(viol_store_pc_i); sid_tab[b] = hsh(viol_store_pc_i);
        end else if (!sid_ok[b]) sid_tab[b] = sid_tab[a];
        else if (!sid_ok[a]) sid_tab[a] = sid_tab[b];
        else begin
          m = (sid_tab[a] < sid_tab[b]) ? sid_tab[a] : sid_tab[b];
          sid_tab[a] = m; sid_tab[b] = m;
        end
        sid_ok[a] = 1; sid_ok[b] = 1;
      end
      for (int s = 0; s < NSET; s++) begin
        if (wdo && wset == s) begin
          lst_ok[s] = 1; lst_seq[s] = ins_seq_i; lst_tid[s] = ins_tid_i;
        end else if ((ido && iset == s && lst_seq[s] == iss_seq_i) ||
                     (sq_valid_i && lst_tid[s] == sq_tid_i && lst_seq[s] > sq_seq_i))
          lst_ok[s] = 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // every-cycle comparison against the reference (R5 lookup path)
  always @(negedge clk)
    if (cmp_on) check("R5 model", int'(look_dep_seq_o), ref_look(look_pc_i));

  task automatic tick();
    @(negedge clk); #2;
    clear_i = 0; viol_valid_i = 0; ins_valid_i = 0; iss_valid_i = 0; sq_valid_i = 0;
  endtask
  task automatic probe(input int unsigned pc, input int exp, input string req);
    look_pc_i = pc; #1; check(req, int'(look_dep_seq_o), exp);
  endtask
  task automatic set_viol(input int unsigned st, input int unsigned ld);
    viol_valid_i = 1; viol_store_pc_i = st; viol_load_pc_i = ld;
  endtask
  task automatic set_ins(input bit st, input int unsigned pc, input int seq, input int tid);
    ins_valid_i = 1; ins_is_store_i = st; ins_pc_i = pc; ins_seq_i = seq; ins_tid_i = tid;
  endtask
  task automatic set_iss(input bit st, input int unsigned pc, input int seq);
    iss_valid_i = 1; iss_is_store_i = st; iss_pc_i = pc; iss_seq_i = seq;
  endtask
  task automatic set_sq(input int tid, input int seq);
    sq_valid_i = 1; sq_tid_i = tid; sq_seq_i = seq;
  endtask

  localparam int unsigned S = 32'h1404, L = 32'h2008, P = 32'h3000;
  localparam int unsigned Q = 32'h040C, M = 32'h0010, R = 32'h003D, N = 32'h0040;
  localparam int unsigned T = 32'h0080;

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #2;
    probe(S, 0, "R9 reset state");
    cmp_on = 1;
    set_viol(S, L); tick();
    probe(L, 0, "R3 no store recorded yet");
    set_ins(1, S, 100, 0);
    probe(L, 0, "R5 insert not visible same cycle");
    tick();
    probe(L, 100, "R4 store recorded"); probe(S, 100, "R4 store sees itself");
    probe(L + 32'h100, 100, "R1 alias above index bits");
    probe(L + 32'h4, 0, "R1 neighbour index empty");
    set_ins(0, L, 101, 0); tick(); probe(L, 100, "R6 load insert inert");
    set_iss(1, S, 99); tick(); probe(L, 100, "R7 older seq keeps entry");
    set_iss(0, L, 100); tick(); probe(L, 100, "R7 load issue inert");
    set_iss(1, S, 100); tick(); probe(L, 0, "R7 matching issue clears");
    set_ins(1, S, 200, 1); tick();
    set_sq(0, 150); tick(); probe(L, 200, "R8 other thread kept");
    set_sq(1, 200); tick(); probe(L, 200, "R8 equal seq kept");
    set_sq(1, 199); tick(); probe(L, 0, "R8 younger squashed");
    set_viol(P, L); tick(); set_ins(1, P, 300, 0); tick();
    probe(L, 300, "R3 copy from valid side");
    set_viol(Q, M); tick(); set_ins(1, M, 500, 0); tick();
    probe(Q, 500, "R3 fresh pair shares set");
    set_viol(R, N); tick(); set_ins(1, R, 550, 0); tick();
    probe(M, 550, "R2 equal hash same set");
    probe(L, 300, "R2 different hash separate set");
    set_viol(Q, L); tick(); set_ins(1, Q, 600, 0); tick();
    probe(L, 600, "R3 min merge joins lower set");
    probe(M, 550, "R3 min merge leaves other pc");
    set_ins(1, 32'h14, 77, 0); tick();
    probe(L, 600, "R4 invalid set ignored"); probe(M, 550, "R4 invalid set ignored");
    set_ins(1, Q, 700, 0); set_iss(1, Q, 600); tick();
    probe(L, 700, "R10 insert beats issue");
    set_ins(1, Q, 800, 0); set_sq(0, 0); tick();
    probe(L, 800, "R10 insert beats squash");
    set_viol(T, L); set_ins(1, T, 900, 0); tick();
    probe(L, 800, "R10 insert uses old set table");
    set_ins(1, T, 950, 0); tick(); probe(L, 950, "R10 later insert lands");
    set_ins(1, Q, 1000, 0); clear_i = 1; tick();
    probe(L, 0, "R9 clear wins");
    set_ins(1, S, 5, 0); tick(); probe(S, 0, "R9 sets gone after clear");
    // randomised traffic against the reference
    for (int k = 0; k < 4000; k++) begin
      int unsigned seq;
      seq = 1000 + k * 3;
      look_pc_i = (($urandom % 8) << 12) | (($urandom % 12) << 2);
      if ($urandom % 5 == 0)
        set_viol((($urandom % 8) << 12) | (($urandom % 12) << 2),
                 (($urandom % 8) << 12) | (($urandom % 12) << 2));
      if ($urandom % 2 == 0)
        set_ins($urandom % 4 != 0, (($urandom % 8) << 12) | (($urandom % 12) << 2),
                seq, $urandom % 4);
      if ($urandom % 3 == 0)
        set_iss($urandom % 4 != 0, (($urandom % 8) << 12) | (($urandom % 12) << 2),
                seq - 3 * ($urandom % 6));
      if ($urandom % 9 == 0) set_sq($urandom % 4, seq - 3 * ($urandom % 10));
      if ($urandom % 300 == 0) clear_i = 1;
      tick();
    end
    cmp_on = 0;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule